// File: doc/BRIEF.md
# Interrupt Dispatcher with Transfer-Server Routing

This block picks the next interrupt for a small controller core to service. Each of its sources can be sent to one of two places. The first is ordinary software service through the source's normal vector. The second is a hardware transfer server, which moves data without running a software routine. For every source the block keeps a pending bit, an enable bit, a transfer-select bit and a transfer-done bit. It resolves a fixed priority among the sources. It then presents a dispatch request: a valid strobe, a kind code, the winning source index and an address.

The address is the normal vector slot for normal and done service. For a transfer-routed request it is the transfer control-block pointer slot. The transfer engine reports the end of a source's transfer count on a counter-zero strobe. In response the block turns off routing for that source and raises a completion (done) interrupt at the same priority slot. That interrupt goes through the source's normal vector. Software turns routing back on by writing the transfer-select bit again. The core accepts a dispatch with an acknowledge strobe.

Top module: `intr_dispatch`

## Requirements
- R1: After a synchronous active-low reset, all per-source bits are clear, disp_valid_o is 0 and no request is offered.
- R2: A pulse on src_req_i[i] sets pending bit i. With source i enabled, its transfer-select bit 0 and glb_int_en_i at 1, the block offers kind 0 (normal) for source i at address VEC_BASE + VEC_STEP*i. With the defaults, source 2 gives 0x2004.
- R3: When several sources are eligible, the one with the highest index is offered.
- R4: Acknowledging a normal or transfer dispatch (ack_i high while disp_valid_o is high) clears that source's pending bit. A new request arriving in the same cycle keeps the bit set.
- R5: A pending, enabled source whose transfer-select bit is 1 is offered as kind 1 (transfer) at address VEC_BASE + XFER_OFS + VEC_STEP*i, for example 0x2044 for source 2. This needs glb_xfer_en_i at 1 and does not depend on glb_int_en_i.
- R6: A counter-zero strobe for source i clears its transfer-select bit and sets its done bit in the next cycle. Later requests from i are therefore offered as normal. The counter-zero strobe takes precedence over a software write in the same cycle.
- R7: A set done bit on an enabled source is offered as kind 2 (done) at the normal vector address VEC_BASE + VEC_STEP*i, in the source's own priority slot. It needs glb_int_en_i at 1. The kind code 3 is never produced.
- R8: Acknowledging a done dispatch clears the done bit and leaves the pending bit unchanged.
- R9: A write with reg_sel_i=1 loads all transfer-select bits from reg_wdata_i. A write with reg_sel_i=0 loads all enable bits. Writing a select bit back to 1 restores transfer routing.
- R10: A source whose enable bit is 0 is never offered. glb_int_en_i at 0 blocks normal and done kinds, and glb_xfer_en_i at 0 blocks the transfer kind.
- R11: Within one source, done is offered before transfer, and transfer before normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req_i | input | NSRC | Per-source request pulses |
| glb_int_en_i | input | 1 | Global gate for normal and done dispatch |
| glb_xfer_en_i | input | 1 | Global gate for transfer dispatch |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Write target: 0 enable bits, 1 transfer-select bits |
| reg_wdata_i | input | NSRC | Write data, one bit per source |
| cnt_zero_i | input | 1 | Transfer count of cnt_src_i reached zero |
| cnt_src_i | input | IW | Source index for cnt_zero_i |
| ack_i | input | 1 | Core accepts the offered dispatch |
| disp_valid_o | output | 1 | A dispatch is offered |
| disp_kind_o | output | 2 | 0 normal, 1 transfer, 2 done |
| disp_src_o | output | IW | Index of the offered source |
| disp_addr_o | output | AW | Vector or control-block pointer address |

## Verification
The hardest state to reach from the ports is a single source that holds a done bit and a fresh pending request together while its select bit has just been cleared. Reaching it needs a precise sequence. The bench first sets the select bit and raises a request. It then issues the counter-zero strobe before any acknowledge, which leaves done and pending both set. It then acknowledges twice, expecting done first and normal second. A further case places a done bit below a higher-index normal request, to confirm that done service keeps its own priority slot.

// File: rtl/intr_pkg.sv
// Shared types for the interrupt dispatcher.
package intr_pkg;
    typedef enum logic [1:0] {
        DK_NORM = 2'd0,
        DK_XFER = 2'd1,
        DK_DONE = 2'd2
    } disp_kind_t;
endpackage

// File: rtl/intr_src_state.sv
// Per-source state bits: pending, enable, transfer-select, done.
// Assumes the clear strobes are already qualified by the parent.
// Counter-zero wins over a software write to the select bit.
module intr_src_state (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic wr_en_i,
    input  logic wr_xs_i,
    input  logic wr_d_i,
    input  logic cnt_zero_i,
    input  logic clr_pend_i,
    input  logic clr_done_i,
    output logic pend_o,
    output logic en_o,
    output logic xsel_o,
    output logic done_o
);
    // Pending: set by request, cleared by accepted dispatch; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend_o <= 1'b0;
        else          pend_o <= req_i | (pend_o & ~clr_pend_i);
    end

    // Enable: loaded by software write.
    always_ff @(posedge clk) begin
        if (!rst_n)        en_o <= 1'b0;
        else if (wr_en_i)  en_o <= wr_d_i;
    end

    // Transfer select: cleared by count exhaustion, else software write.
    always_ff @(posedge clk) begin
        if (!rst_n)          xsel_o <= 1'b0;
        else if (cnt_zero_i) xsel_o <= 1'b0;
        else if (wr_xs_i)    xsel_o <= wr_d_i;
    end

    // Done: set by count exhaustion, cleared when its dispatch is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)          done_o <= 1'b0;
        else if (cnt_zero_i) done_o <= 1'b1;
        else if (clr_done_i) done_o <= 1'b0;
    end
endmodule

// File: rtl/intr_prio_pick.sv
// Fixed-priority selector: the highest set index wins.
// Assumes NSRC >= 2.
module intr_prio_pick #(
    parameter int NSRC = 8,
    localparam int IW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] act_i,
    output logic            valid_o,
    output logic [IW-1:0]   idx_o
);
    // Scan upward so later (higher) indices overwrite lower ones.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (act_i[i]) idx_o = IW'(i);
        end
        valid_o = |act_i;
    end
endmodule

// File: rtl/intr_dispatch.sv
// Interrupt dispatcher with transfer-server routing.
// Holds per-source state, finds the highest eligible source and offers it
// as a normal, transfer or done dispatch, with its vector address.
// Assumes ack_i is only meaningful while disp_valid_o is high.
module intr_dispatch
    import intr_pkg::*;
#(
    parameter int NSRC     = 8,
    parameter int AW       = 16,
    parameter int VEC_BASE = 'h2000,
    parameter int XFER_OFS = 'h40,
    parameter int VEC_STEP = 2,
    localparam int IW      = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req_i,
    input  logic            glb_int_en_i,
    input  logic            glb_xfer_en_i,
    input  logic            reg_wr_i,
    input  logic            reg_sel_i,
    input  logic [NSRC-1:0] reg_wdata_i,
    input  logic            cnt_zero_i,
    input  logic [IW-1:0]   cnt_src_i,
    input  logic            ack_i,
    output logic            disp_valid_o,
    output logic [1:0]      disp_kind_o,
    output logic [IW-1:0]   disp_src_o,
    output logic [AW-1:0]   disp_addr_o
);
    logic [NSRC-1:0] pend_q, en_q, xsel_q, done_q;
    logic [NSRC-1:0] want_done, want_xfer, want_norm, act;
    logic [NSRC-1:0] clr_pend, clr_done;
    logic [IW-1:0]   sel;
    logic            any;
    logic            take;
    disp_kind_t      kind;

    // Per-source eligibility for each kind of dispatch.
    always_comb begin
        want_done = done_q & en_q & {NSRC{glb_int_en_i}};
        want_xfer = pend_q & en_q & xsel_q & {NSRC{glb_xfer_en_i}};
        want_norm = pend_q & en_q & ~xsel_q & {NSRC{glb_int_en_i}};
        act       = want_done | want_xfer | want_norm;
    end

    intr_prio_pick #(.NSRC(NSRC)) u_pick (
        .act_i   (act),
        .valid_o (any),
        .idx_o   (sel)
    );

    // Kind of the winner: done before transfer before normal.
    always_comb begin
        if (want_done[sel])      kind = DK_DONE;
        else if (want_xfer[sel]) kind = DK_XFER;
        else                     kind = DK_NORM;
    end

    // Dispatch outputs and vector address.
    always_comb begin
        disp_valid_o = any;
        disp_kind_o  = kind;
        disp_src_o   = sel;
        disp_addr_o  = AW'(VEC_BASE) + AW'(sel) * AW'(VEC_STEP);
        if (kind == DK_XFER) disp_addr_o = disp_addr_o + AW'(XFER_OFS);
    end

    // Acknowledge decode into per-source clear strobes.
    always_comb begin
        take = ack_i & any;
        for (int i = 0; i < NSRC; i++) begin
            clr_pend[i] = take && (sel == IW'(i)) && (kind != DK_DONE);
            clr_done[i] = take && (sel == IW'(i)) && (kind == DK_DONE);
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        intr_src_state u_st (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_i      (src_req_i[g]),
            .wr_en_i    (reg_wr_i & ~reg_sel_i),
            .wr_xs_i    (reg_wr_i & reg_sel_i),
            .wr_d_i     (reg_wdata_i[g]),
            .cnt_zero_i (cnt_zero_i && (cnt_src_i == IW'(g))),
            .clr_pend_i (clr_pend[g]),
            .clr_done_i (clr_done[g]),
            .pend_o     (pend_q[g]),
            .en_o       (en_q[g]),
            .xsel_o     (xsel_q[g]),
            .done_o     (done_q[g])
        );
    end

    logic req_at_sel;
    assign req_at_sel = src_req_i[sel];

    p_pend_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && disp_valid_o && disp_kind_o != 2'd2)
        |=> pend_q[$past(disp_src_o)] == $past(req_at_sel));

    p_xsel_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_zero_i |=> (!xsel_q[$past(cnt_src_i)] && done_q[$past(cnt_src_i)]));

    p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && disp_valid_o && disp_kind_o == 2'd2 &&
         !(cnt_zero_i && cnt_src_i == disp_src_o))
        |=> !done_q[$past(disp_src_o)]);

    p_kind_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid_o |-> disp_kind_o != 2'd3);

    p_norm_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid_o && disp_kind_o != 2'd1) |-> glb_int_en_i);

    p_xfer_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid_o && disp_kind_o == 2'd1) |-> glb_xfer_en_i);
endmodule

// File: tb/sim_intr_dispatch.sv
module sim_intr_dispatch;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_req = '0;
    logic       gie = 1'b0, gte = 1'b0;
    logic       reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       cnt_zero = 1'b0;
    logic [2:0] cnt_src = '0;
    logic       ack = 1'b0;
    logic       d_valid;
    logic [1:0] d_kind;
    logic [2:0] d_src;
    logic [15:0] d_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct {
        logic        v;
        logic [1:0]  k;
        logic [2:0]  s;
        logic [15:0] a;
        string       tag;
    } exp_t;

    exp_t sb[$];
    event chk_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .src_req_i(src_req),
        .glb_int_en_i(gie), .glb_xfer_en_i(gte),
        .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
        .cnt_zero_i(cnt_zero), .cnt_src_i(cnt_src), .ack_i(ack),
        .disp_valid_o(d_valid), .disp_kind_o(d_kind),
        .disp_src_o(d_src), .disp_addr_o(d_addr)
    );

    // Monitor: pop expected items and compare with the offered dispatch.
    always @(chk_ev) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (d_valid !== e.v ||
                (e.v && (d_kind !== e.k || d_src !== e.s || d_addr !== e.a))) begin
                errors++;
                $display("FAIL %s: got v=%b k=%0d s=%0d a=%h, expected v=%b k=%0d s=%0d a=%h",
                         e.tag, d_valid, d_kind, d_src, d_addr, e.v, e.k, e.s, e.a);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 10000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles, expected fewer", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_d(logic v, logic [1:0] k, logic [2:0] s, logic [15:0] a, string tag);
        exp_t e;
        e.v = v; e.k = k; e.s = s; e.a = a; e.tag = tag;
        sb.push_back(e);
        ->chk_ev;
        #1;
    endtask

    task automatic req(logic [7:0] m);
        src_req = m; tick(); src_req = '0;
    endtask

    task automatic acknowledge();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic wr(logic sel, logic [7:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d; tick(); reg_wr = 1'b0;
    endtask

    task automatic czero(logic [2:0] s);
        cnt_zero = 1'b1; cnt_src = s; tick(); cnt_zero = 1'b0;
    endtask

    initial begin
        tick(); tick();
        expect_d(0, 0, 0, 0, "R1 reset idle");
        rst_n = 1'b1;
        req(8'h04);
        expect_d(0, 0, 0, 0, "R1 enables clear after reset");
        wr(0, 8'hFF);
        gie = 1'b1; gte = 1'b1;
        expect_d(1, 0, 2, 16'h2004, "R2 normal source 2");
        acknowledge();
        expect_d(0, 0, 0, 0, "R4 pending cleared");

        req(8'h28);
        expect_d(1, 0, 5, 16'h200A, "R3 source 5 beats 3");
        acknowledge();
        expect_d(1, 0, 3, 16'h2006, "R3 source 3 next");
        acknowledge();
        expect_d(0, 0, 0, 0, "R4 all served");

        wr(0, 8'hFB);
        req(8'h04);
        expect_d(0, 0, 0, 0, "R10 disabled source hidden");
        wr(0, 8'hFF);
        expect_d(1, 0, 2, 16'h2004, "R10 shown when enabled");
        acknowledge();

        gie = 1'b0;
        req(8'h02);
        expect_d(0, 0, 0, 0, "R10 global gate blocks normal");
        gie = 1'b1;
        expect_d(1, 0, 1, 16'h2002, "R2 normal source 1");
        acknowledge();

        wr(1, 8'h10);
        req(8'h10);
        expect_d(1, 1, 4, 16'h2048, "R5 transfer source 4");
        gie = 1'b0;
        expect_d(1, 1, 4, 16'h2048, "R5 transfer ignores int gate");
        gie = 1'b1; gte = 1'b0;
        expect_d(0, 0, 0, 0, "R10 transfer gate blocks");
        gte = 1'b1;
        acknowledge();
        expect_d(0, 0, 0, 0, "R4 transfer ack clears pending");

        czero(3'd4);
        expect_d(1, 2, 4, 16'h2008, "R7 done via normal vector");
        acknowledge();
        expect_d(0, 0, 0, 0, "R8 done cleared, pending stays 0");
        req(8'h10);
        expect_d(1, 0, 4, 16'h2008, "R6 select cleared, normal now");
        acknowledge();

        wr(1, 8'h40);
        req(8'h40);
        czero(3'd6);
        expect_d(1, 2, 6, 16'h200C, "R11 done before normal");
        acknowledge();
        expect_d(1, 0, 6, 16'h200C, "R8 pending kept after done ack");
        acknowledge();
        expect_d(0, 0, 0, 0, "R4 source 6 served");

        wr(1, 8'h40);
        req(8'h40);
        expect_d(1, 1, 6, 16'h204C, "R9 routing restored");
        acknowledge();

        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h02;
        cnt_zero = 1'b1; cnt_src = 3'd1;
        tick();
        reg_wr = 1'b0; cnt_zero = 1'b0;
        req(8'h80);
        expect_d(1, 0, 7, 16'h200E, "R3 source 7 above done on 1");
        acknowledge();
        expect_d(1, 2, 1, 16'h2002, "R7 done keeps slot of source 1");
        req(8'h02);
        expect_d(1, 2, 1, 16'h2002, "R6 count-zero beat write; done first");
        acknowledge();
        expect_d(1, 0, 1, 16'h2002, "R6 normal after done, select off");
        acknowledge();
        expect_d(0, 0, 0, 0, "R4 idle at end");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule